// File: doc/BRIEF.md
# Triggered Burst Capture Buffer

This block records one burst of converter samples into on-chip memory when a trigger edge arrives, and then lets a slow host fetch the record one sample per request. The converter side delivers four 8-bit samples per clock on four parallel lanes, one lane per quarter-rate phase. Each lane writes its own memory bank, so every bank runs at a quarter of the sample rate. A full record is 4096 samples, held as 1024 entries in each of the four banks.

Software pulses an arm input. The next rising edge of the trigger starts a capture. From the first clock after that edge, every clock writes the four lane samples into the same entry of the four banks and then moves to the next entry. When the last entry has been written, a ready flag rises and stays high until the next arm. The host then reads with a single address that counts samples in time order. The block works out the bank and the entry, and returns the sample one cycle later with a valid strobe.

Top module: `burst_capture_top`

## Requirements
- R1: While reset is high and in the cycle after it, `ready` and `rd_valid` are 0, and the block stays idle until it is armed.
- R2: A one-cycle pulse on `arm`, in any state, clears `ready` and the write entry counter and enables the trigger. No memory is written until a trigger edge follows.
- R3: On the first clock after the trigger edge is sampled, the four lanes are written into entry 0. Lane j (bits 8j+7:8j of `lane_data`) goes to bank j. Each later clock writes the next entry, so sample index 4e+j sits in entry e of bank j.
- R4: A capture writes exactly 1024 entries per bank, a 4096-sample record. `ready` is 0 up to and including the cycle of the last write and is 1 from the next cycle.
- R5: A trigger edge is acted on only when armed and not yet capturing. Trigger activity before arming, during a capture or after the record is complete has no effect. A trigger that is already high when `arm` pulses starts nothing until it falls and rises again.
- R6: `ready` stays 1 until the next `arm`, and the stored record is never overwritten while `ready` is 1.
- R7: When `rd_en` is high with address k, then on the next cycle `rd_valid` is 1 and `rd_data` holds the sample from bank k[1:0], entry k[11:2]. `rd_valid` is 0 in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and read clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that prepares a new capture |
| trig | input | 1 | Trigger level; its rising edge starts a capture |
| lane_data | input | 32 | Four 8-bit samples per clock, lane 0 in the low byte |
| ready | output | 1 | Record complete and available to the host |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 12 | Sample index in time order |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Sample returned for the previous request |

## Verification
The properties take `arm` to be a single-cycle pulse, `trig` to be synchronous to `clk`, and `rd_addr` to stay inside the 4096-sample record. The bench changes every input on the falling edge, so each rising edge sees stable values. It pulses `arm` for exactly one cycle and only issues read addresses below 4096. It never starts a host read during a capture, so the readback values depend only on completed records.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int BANK_DEPTH = 1024,
  localparam int ENTRY_W = $clog2(BANK_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               trig,
  output logic               wr_en,
  output logic [ENTRY_W-1:0] wr_entry,
  output logic               ready
);

  localparam logic [ENTRY_W-1:0] LAST_ENTRY = ENTRY_W'(BANK_DEPTH - 1);

  cap_state_t state;
  logic       trig_q;
  logic       trig_rise;

  // Edge detector: a level held high gives one start only.
  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig;
  end

  assign trig_rise = trig & ~trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_entry <= '0;
      ready    <= 1'b0;
    end else if (arm) begin
      state    <= ST_ARMED;
      wr_entry <= '0;
      ready    <= 1'b0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (trig_rise) begin
            state    <= ST_CAPT;
            wr_entry <= '0;
          end
        end
        ST_CAPT: begin
          if (wr_entry == LAST_ENTRY) begin
            state <= ST_DONE;
            ready <= 1'b1;
          end else begin
            wr_entry <= wr_entry + 1'b1;
          end
        end
        default: begin
          state <= state;
        end
      endcase
    end
  end

  assign wr_en = (state == ST_CAPT);

endmodule

// File: rtl/cap_bank.sv
module cap_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cap_readport.sv
module cap_readport #(
  parameter int LANES    = 4,
  parameter int DATA_W   = 8,
  parameter int ENTRY_W  = 10,
  localparam int SEL_W   = $clog2(LANES),
  localparam int ADDR_W  = ENTRY_W + SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    bank_re,
  output logic [ENTRY_W-1:0]      bank_raddr,
  input  logic [LANES*DATA_W-1:0] bank_rdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data
);

  logic [SEL_W-1:0] sel_q;

  // Low bits pick the bank (lane phase), high bits the entry.
  assign bank_re    = rd_en;
  assign bank_raddr = rd_addr[ADDR_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) sel_q <= rd_addr[SEL_W-1:0];
    end
  end

  assign rd_data = bank_rdata[sel_q*DATA_W +: DATA_W];

endmodule

// File: rtl/burst_capture_top.sv
module burst_capture_top #(
  parameter int SAMPLE_W   = 8,
  parameter int LANES      = 4,
  parameter int BANK_DEPTH = 1024,
  localparam int SEL_W     = $clog2(LANES),
  localparam int ENTRY_W   = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = ENTRY_W + SEL_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      arm,
  input  logic                      trig,
  input  logic [LANES*SAMPLE_W-1:0] lane_data,
  output logic                      ready,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic                      rd_valid,
  output logic [SAMPLE_W-1:0]       rd_data
);

  logic                      wr_en;
  logic [ENTRY_W-1:0]        wr_entry;
  logic                      bank_re;
  logic [ENTRY_W-1:0]        bank_raddr;
  logic [LANES*SAMPLE_W-1:0] bank_rdata;

  cap_ctrl #(
    .BANK_DEPTH(BANK_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .trig     (trig),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .ready    (ready)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    cap_bank #(
      .DATA_W (SAMPLE_W),
      .DEPTH  (BANK_DEPTH)
    ) u_bank (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_entry),
      .wdata (lane_data[b*SAMPLE_W +: SAMPLE_W]),
      .re    (bank_re),
      .raddr (bank_raddr),
      .rdata (bank_rdata[b*SAMPLE_W +: SAMPLE_W])
    );
  end

  cap_readport #(
    .LANES   (LANES),
    .DATA_W  (SAMPLE_W),
    .ENTRY_W (ENTRY_W)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .bank_re    (bank_re),
    .bank_raddr (bank_raddr),
    .bank_rdata (bank_rdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/burst_capture_chk.sv
module burst_capture_chk #(
  parameter int BANK_DEPTH = 1024,
  localparam int ENTRY_W = $clog2(BANK_DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic               arm,
  input logic               trig,
  input logic               ready,
  input logic               rd_en,
  input logic               rd_valid,
  input logic               wr_en,
  input logic [ENTRY_W-1:0] wr_entry
);

  localparam logic [ENTRY_W-1:0] LAST_ENTRY = ENTRY_W'(BANK_DEPTH - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ready && !rd_valid)); // R1
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst) arm |=> (!ready && !wr_en)); // R2
  AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(wr_en) |-> (wr_entry == '0)); // R3
  AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (rst) wr_en |=> (!wr_en || wr_entry == $past(wr_entry) + 1'b1)); // R3
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_entry == LAST_ENTRY && !arm) |=> ready); // R4
  AST_EDGE_START: assert property (@(posedge clk) disable iff (rst) $rose(wr_en) |-> ($past(trig) && !$past(trig, 2))); // R5
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst) (ready && !arm) |=> ready); // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst) ready |-> !wr_en); // R6
  AST_RD_VALID_ON: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R7
  AST_RD_VALID_OFF: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid); // R7

endmodule

bind burst_capture_top burst_capture_chk #(
  .BANK_DEPTH(BANK_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .arm      (arm),
  .trig     (trig),
  .ready    (ready),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .wr_en    (wr_en),
  .wr_entry (wr_entry)
);

// File: tb/sim_burst_capture_top.sv
`timescale 1ns/1ps
module sim_burst_capture_top;

  localparam int SW    = 8;
  localparam int LN    = 4;
  localparam int DEPTH = 1024;
  localparam int REC   = LN * DEPTH;
  localparam int SEED1 = 11;
  localparam int SEED2 = 77;

  function automatic logic [7:0] pat(input int seed, input int idx);
    int v;
    v = idx * 29 + (idx >>> 8) * 3 + seed;
    return v[7:0];
  endfunction

  // Read vectors for the first record: {address, expected sample}.
  localparam int NVEC = 14;
  localparam logic [19:0] VEC [NVEC] = '{
    {12'd0,    pat(SEED1, 0)},
    {12'd1,    pat(SEED1, 1)},
    {12'd2,    pat(SEED1, 2)},
    {12'd3,    pat(SEED1, 3)},
    {12'd4,    pat(SEED1, 4)},
    {12'd7,    pat(SEED1, 7)},
    {12'd255,  pat(SEED1, 255)},
    {12'd256,  pat(SEED1, 256)},
    {12'd1023, pat(SEED1, 1023)},
    {12'd2048, pat(SEED1, 2048)},
    {12'd4092, pat(SEED1, 4092)},
    {12'd4093, pat(SEED1, 4093)},
    {12'd4094, pat(SEED1, 4094)},
    {12'd4095, pat(SEED1, 4095)}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           arm = 1'b0;
  logic           trig = 1'b0;
  logic [LN*SW-1:0] lane_data = '0;
  logic           ready;
  logic           rd_en = 1'b0;
  logic [11:0]    rd_addr = '0;
  logic           rd_valid;
  logic [SW-1:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_capture_top #(
    .SAMPLE_W(SW), .LANES(LN), .BANK_DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .lane_data(lane_data),
    .ready(ready), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic drive_lanes(input int seed, input int entry);
    for (int j = 0; j < LN; j++) lane_data[j*SW +: SW] = pat(seed, entry * LN + j);
  endtask

  // Host read: returns data seen one cycle after the request.
  task automatic host_read(input int addr, output bit vld, output logic [7:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 12'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    vld = rd_valid;
    d   = rd_data;
  endtask

  // Capture with a rising trigger, plus a stray trigger pulse mid-capture (R5).
  task automatic run_capture(input int seed, input int stray_at);
    @(negedge clk);
    trig = 1'b1;
    @(posedge clk);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      drive_lanes(seed, k);
      trig = (k < 2) || (k == stray_at) || (k == stray_at + 1);
      if (k == DEPTH - 1) chk(ready == 1'b0, "R4 ready low through last write", int'(ready), 0);
      @(posedge clk);
    end
    @(negedge clk);
    chk(ready == 1'b1, "R4 ready after last entry", int'(ready), 1);
    trig = 1'b0;
  endtask

  task automatic walk_table(input string req);
    bit vld;
    logic [7:0] d;
    for (int i = 0; i < NVEC; i++) begin
      host_read(int'(VEC[i][19:8]), vld, d);
      chk(vld == 1'b1, req, int'(vld), 1);
      chk(d == VEC[i][7:0], req, int'(d), int'(VEC[i][7:0]));
    end
  endtask

  task automatic full_readback(input int seed, input string req);
    bit vld;
    logic [7:0] d;
    int bad;
    bad = 0;
    for (int a = 0; a < REC; a++) begin
      host_read(a, vld, d);
      if (!vld || d != pat(seed, a)) begin
        bad++;
        if (bad < 4) chk(1'b0, req, int'(d), int'(pat(seed, a)));
      end
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    bit vld;
    logic [7:0] d;

    // R1 reset state
    idle_cycles(4);
    chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", int'(ready), 0);

    // R5 trigger while idle starts nothing
    trig = 1'b1;
    idle_cycles(2);
    trig = 1'b0;
    idle_cycles(DEPTH + 8);
    chk(ready == 1'b0, "R5 idle trigger ignored", int'(ready), 0);

    // R7 valid strobe and its drop
    host_read(5, vld, d);
    chk(vld == 1'b1, "R7 rd_valid after request", int'(vld), 1);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 rd_valid drops", int'(rd_valid), 0);

    // R2 arm, then nothing until trigger
    pulse_arm();
    idle_cycles(DEPTH + 8);
    chk(ready == 1'b0, "R2 armed waits for trigger", int'(ready), 0);

    // R3/R4 first capture with a stray trigger in the middle (R5)
    run_capture(SEED1, 500);
    walk_table("R7 table readback");
    full_readback(SEED1, "R3 record order");

    // R6 trigger after completion: ready holds, record untouched
    @(negedge clk);
    drive_lanes(SEED2, 0);
    trig = 1'b1;
    idle_cycles(3);
    trig = 1'b0;
    idle_cycles(DEPTH + 8);
    chk(ready == 1'b1, "R6 ready holds after trigger", int'(ready), 1);
    walk_table("R6 record kept");

    // R2/R5 arm with trigger already high: no start
    @(negedge clk);
    trig = 1'b1;
    pulse_arm();
    chk(ready == 1'b0, "R2 arm clears ready", int'(ready), 0);
    idle_cycles(DEPTH + 8);
    chk(ready == 1'b0, "R5 held trigger ignored", int'(ready), 0);
    walk_table("R5 no write from held trigger");
    @(negedge clk);
    trig = 1'b0;
    idle_cycles(2);

    // Second capture with a new pattern
    run_capture(SEED2, 700);
    host_read(0, vld, d);
    chk(d == pat(SEED2, 0), "R3 second record first sample", int'(d), int'(pat(SEED2, 0)));
    host_read(4095, vld, d);
    chk(d == pat(SEED2, 4095), "R3 second record last sample", int'(d), int'(pat(SEED2, 4095)));
    host_read(1029, vld, d);
    chk(d == pat(SEED2, 1029), "R7 bank 1 entry 257", int'(d), int'(pat(SEED2, 1029)));

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule